// File: doc/BRIEF.md
# Sync-Derived Data-Enable Generator

This block rebuilds the data-enable qualifier of a video stream from its horizontal and vertical sync inputs, in the pixel clock domain. A pixel counter restarts whenever the horizontal sync becomes active, and a line counter restarts whenever the vertical sync becomes active. The enable is raised only inside a rectangle. Programmable values set that rectangle: a horizontal delay, an active width, a top offset and an active height. The polarity of each sync input can be chosen.

A control bit selects the source of the enable. When generation is on, the internal enable drives the output and the external enable pin is ignored. When generation is off, the external enable passes through. Both paths carry the same single register stage, so they stay aligned. All settings sit in a small byte-wide register file behind a plain address/data port. Writes take effect on a clock edge and reads are combinational. There is no streaming data interface, so no valid/ready handshake or back-pressure applies: every pin is a plain control or status level.

Top module: `syncde_gen`

## Requirements
- R1: After reset every register reads 0x00. Address 0x32 holds delay bits 7:0 and 0x34 holds the 8-bit top offset. Address 0x35 holds width bits 7:0, and 0x36 holds width bits 11:8 in its bits 3:0. Address 0x37 holds height bits 7:0, and 0x38 holds height bits 10:8 in its bits 2:0. Each register reads back what was written, with its unused upper bits read as 0.
- R2: Control register 0x33 maps delay bit 8 to bit 0, horizontal polarity to bit 4, vertical polarity to bit 5 and generator enable to bit 6. Its bits 7, 3, 2 and 1 read 0 and ignore writes. Any address outside 0x32..0x38 reads 0x00.
- R3: A polarity bit of 1 makes its sync input active high, and a 0 makes it active low. An active edge is the clock where the normalised (active-high) sync is 1 after being 0 on the previous clock.
- R4: The pixel count becomes 0 on the clock after a horizontal active edge and then increments each clock, saturating at its maximum. The enable covers pixel counts delay to delay+width-1, where delay is 9 bits wide. A width of 0 gives no enable.
- R5: The line count becomes 0 after a vertical active edge and increments after each horizontal active edge. When both edges arrive in the same clock, the vertical edge wins. The enable is allowed only on line counts top to top+height-1.
- R6: With the default sizes the line counter is 12 bits wide and holds at 4095 when no vertical edge arrives, instead of wrapping.
- R7: With the generator bit set, the external enable input has no effect on the output.
- R8: With the generator bit clear, the output equals the external enable input delayed by exactly one clock.
- R9: The output is registered. When the horizontal sync goes active before clock edge k, the output is high after edges k+delay+1 through k+delay+width on an enabled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, polarity programmable |
| vsync_in | input | 1 | Vertical sync, polarity programmable |
| de_ext_in | input | 1 | External data enable for bypass |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| de_out | output | 1 | Registered data enable |

## Verification
Register reads are combinational, so the bench applies an address and samples cfg_rdata a moment later in the same cycle. A write is due after the next rising edge. The bench drives every input at a falling edge and samples at falling edges. For a horizontal sync driven just before edge 1 of a line, the pixel count is m after edge m+1. The output shows that count one edge later, so the first high sample comes at falling edge delay+2. Each line task records the index of the first high sample and the number of high samples, and compares them with delay+2 and width. For bypass, the bench confirms that the output still holds the old value just after driving a new external enable, and holds the new value one clock later.

// File: rtl/syncde_pkg.sv
package syncde_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int DLY_W  = 9;
  localparam int TOP_W  = 8;

  localparam logic [ADDR_W-1:0] A_DLY_LO = 8'h32;
  localparam logic [ADDR_W-1:0] A_CTL    = 8'h33;
  localparam logic [ADDR_W-1:0] A_TOP    = 8'h34;
  localparam logic [ADDR_W-1:0] A_WID_LO = 8'h35;
  localparam logic [ADDR_W-1:0] A_WID_HI = 8'h36;
  localparam logic [ADDR_W-1:0] A_HGT_LO = 8'h37;
  localparam logic [ADDR_W-1:0] A_HGT_HI = 8'h38;

  localparam int B_DLY_MSB = 0;
  localparam int B_HPOL    = 4;
  localparam int B_VPOL    = 5;
  localparam int B_GEN     = 6;

  typedef struct packed {
    logic gen;
    logic vpol;
    logic hpol;
  } ctl_t;
endpackage

// File: rtl/syncde_regs.sv
module syncde_regs
  import syncde_pkg::*;
#(
  parameter int WID_W = 12,
  parameter int HGT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DLY_W-1:0]  dly,
  output logic [TOP_W-1:0]  top,
  output logic [WID_W-1:0]  wid,
  output logic [HGT_W-1:0]  hgt,
  output ctl_t              ctl
);
  localparam int WHI_W = WID_W - DATA_W;
  localparam int HHI_W = HGT_W - DATA_W;

  logic [DATA_W-1:0] dly_lo_q, top_q, wid_lo_q, hgt_lo_q;
  logic [WHI_W-1:0]  wid_hi_q;
  logic [HHI_W-1:0]  hgt_hi_q;
  logic              dly_msb_q;
  ctl_t              ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_lo_q  <= '0;
      top_q     <= '0;
      wid_lo_q  <= '0;
      hgt_lo_q  <= '0;
      wid_hi_q  <= '0;
      hgt_hi_q  <= '0;
      dly_msb_q <= 1'b0;
      ctl_q     <= '0;
    end else if (we) begin
      case (addr)
        A_DLY_LO: dly_lo_q <= wdata;
        A_CTL: begin
          dly_msb_q  <= wdata[B_DLY_MSB];
          ctl_q.hpol <= wdata[B_HPOL];
          ctl_q.vpol <= wdata[B_VPOL];
          ctl_q.gen  <= wdata[B_GEN];
        end
        A_TOP:    top_q    <= wdata;
        A_WID_LO: wid_lo_q <= wdata;
        A_WID_HI: wid_hi_q <= wdata[WHI_W-1:0];
        A_HGT_LO: hgt_lo_q <= wdata;
        A_HGT_HI: hgt_hi_q <= wdata[HHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DLY_LO: rdata = dly_lo_q;
      A_CTL: begin
        rdata[B_DLY_MSB] = dly_msb_q;
        rdata[B_HPOL]    = ctl_q.hpol;
        rdata[B_VPOL]    = ctl_q.vpol;
        rdata[B_GEN]     = ctl_q.gen;
      end
      A_TOP:    rdata = top_q;
      A_WID_LO: rdata = wid_lo_q;
      A_WID_HI: rdata[WHI_W-1:0] = wid_hi_q;
      A_HGT_LO: rdata = hgt_lo_q;
      A_HGT_HI: rdata[HHI_W-1:0] = hgt_hi_q;
      default:  rdata = '0;
    endcase
  end

  assign dly = {dly_msb_q, dly_lo_q};
  assign top = top_q;
  assign wid = {wid_hi_q, wid_lo_q};
  assign hgt = {hgt_hi_q, hgt_lo_q};
  assign ctl = ctl_q;
endmodule

// File: rtl/syncde_edge.sv
module syncde_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic act_high,
  output logic edge_o
);
  logic norm, norm_q;

  assign norm = act_high ? raw : ~raw;

  always_ff @(posedge clk) begin
    if (!rst_n) norm_q <= 1'b0;
    else        norm_q <= norm;
  end

  assign edge_o = norm & ~norm_q;
endmodule

// File: rtl/syncde_count.sv
module syncde_count #(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_edge,
  input  logic              v_edge,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)              pix <= '0;
    else if (h_edge)         pix <= '0;
    else if (pix != PIX_MAX) pix <= pix + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          line <= '0;
    else if (v_edge)                     line <= '0;
    else if (h_edge && line != LINE_MAX) line <= line + 1'b1;
  end
endmodule

// File: rtl/syncde_window.sv
module syncde_window
  import syncde_pkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 12,
  parameter int WID_W  = 12,
  parameter int HGT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic [DLY_W-1:0]  dly,
  input  logic [WID_W-1:0]  wid,
  input  logic [TOP_W-1:0]  top,
  input  logic [HGT_W-1:0]  hgt,
  input  logic              gen,
  input  logic              de_ext,
  output logic              de_out
);
  localparam int HS_W = PIX_W + 1;
  localparam int VS_W = LINE_W + 1;

  logic [HS_W-1:0] h_pos, h_lo, h_hi;
  logic [VS_W-1:0] v_pos, v_lo, v_hi;
  logic            h_ok, v_ok;

  always_comb begin
    h_pos = HS_W'(pix);
    h_lo  = HS_W'(dly);
    h_hi  = h_lo + HS_W'(wid);
    v_pos = VS_W'(line);
    v_lo  = VS_W'(top);
    v_hi  = v_lo + VS_W'(hgt);
    h_ok  = (h_pos >= h_lo) && (h_pos < h_hi);
    v_ok  = (v_pos >= v_lo) && (v_pos < v_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) de_out <= 1'b0;
    else        de_out <= gen ? (h_ok && v_ok) : de_ext;
  end
endmodule

// File: rtl/syncde_gen.sv
module syncde_gen
  import syncde_pkg::*;
#(
  parameter int WID_W = 12,
  parameter int HGT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              de_ext_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              de_out
);
  localparam int PIX_W  = ((DLY_W > WID_W) ? DLY_W : WID_W) + 1;
  localparam int LINE_W = ((TOP_W > HGT_W) ? TOP_W : HGT_W) + 1;
  localparam int N_SYNC = 2;

  logic [DLY_W-1:0]  dly;
  logic [TOP_W-1:0]  top;
  logic [WID_W-1:0]  wid;
  logic [HGT_W-1:0]  hgt;
  ctl_t              ctl;
  logic [N_SYNC-1:0] sync_raw, sync_pol, sync_edge;
  logic              h_edge, v_edge;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;

  syncde_regs #(.WID_W(WID_W), .HGT_W(HGT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .dly(dly), .top(top), .wid(wid), .hgt(hgt), .ctl(ctl)
  );

  assign sync_raw = {vsync_in, hsync_in};
  assign sync_pol = {ctl.vpol, ctl.hpol};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    syncde_edge edge_i (
      .clk(clk), .rst_n(rst_n), .raw(sync_raw[g]),
      .act_high(sync_pol[g]), .edge_o(sync_edge[g])
    );
  end

  assign h_edge = sync_edge[0];
  assign v_edge = sync_edge[1];

  syncde_count #(.PIX_W(PIX_W), .LINE_W(LINE_W)) count_i (
    .clk(clk), .rst_n(rst_n), .h_edge(h_edge), .v_edge(v_edge),
    .pix(pix), .line(line)
  );

  syncde_window #(.PIX_W(PIX_W), .LINE_W(LINE_W), .WID_W(WID_W), .HGT_W(HGT_W)) win_i (
    .clk(clk), .rst_n(rst_n), .pix(pix), .line(line),
    .dly(dly), .wid(wid), .top(top), .hgt(hgt),
    .gen(ctl.gen), .de_ext(de_ext_in), .de_out(de_out)
  );
endmodule

// File: rtl/syncde_chk.sv
module syncde_chk
  import syncde_pkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 12,
  parameter int WID_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_edge,
  input logic              v_edge,
  input logic [PIX_W-1:0]  pix,
  input logic [LINE_W-1:0] line,
  input logic [WID_W-1:0]  wid,
  input logic              gen,
  input logic              de_ext_in,
  input logic              de_out,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata
);
  localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r4_pix_restart: assert property (@(posedge clk) disable iff (!rst_n)
    h_edge |=> (pix == '0));

  a_r5_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> (line == '0));

  a_r6_line_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LMAX && !v_edge) |=> (line == LMAX));

  a_r8_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !gen) |=> (de_out == $past(de_ext_in)));

  a_r4_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && gen && wid == '0) |=> !de_out);

  a_r2_ctl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == A_CTL) |-> (cfg_rdata[7] == 1'b0 && cfg_rdata[3:1] == 3'b000));

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < A_DLY_LO || cfg_addr > A_HGT_HI) |-> (cfg_rdata == '0));
endmodule

bind syncde_gen syncde_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W), .WID_W(WID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .h_edge(h_edge), .v_edge(v_edge),
  .pix(pix), .line(line), .wid(wid), .gen(ctl.gen),
  .de_ext_in(de_ext_in), .de_out(de_out),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/syncde_gen_tb_top.sv
module syncde_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0, de_ext_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       de_out;
  logic       hact = 1'b1, vact = 1'b1;
  int         checks = 0, failures = 0;

  always #10 clk = ~clk;

  syncde_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .de_ext_in(de_ext_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .de_out(de_out)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(req, int'(cfg_rdata), int'(exp), $sformatf("read 0x%02h", a));
  endtask

  task automatic run_line(input bit vs, input int len, output int first, output int cnt);
    first = -1; cnt = 0;
    @(negedge clk);
    hsync_in = hact;
    if (vs) vsync_in = vact;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (j == 1) begin hsync_in = ~hact; vsync_in = ~vact; end
      if (de_out) begin
        if (first < 0) first = j;
        cnt++;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", int'(de_out), 0, "de_out after reset");
    for (int a = 8'h32; a <= 8'h38; a++) rd_chk("R1", 8'(a), 8'h00);
  endtask

  task automatic t_regs();
    wr(8'h32, 8'hA5); rd_chk("R1", 8'h32, 8'hA5);
    wr(8'h34, 8'h3C); rd_chk("R1", 8'h34, 8'h3C);
    wr(8'h35, 8'h5A); rd_chk("R1", 8'h35, 8'h5A);
    wr(8'h36, 8'hFF); rd_chk("R1", 8'h36, 8'h0F);
    wr(8'h37, 8'hC3); rd_chk("R1", 8'h37, 8'hC3);
    wr(8'h38, 8'hFF); rd_chk("R1", 8'h38, 8'h07);
    wr(8'h33, 8'hFF); rd_chk("R2", 8'h33, 8'h71);
    wr(8'h40, 8'hFF); rd_chk("R2", 8'h40, 8'h00);
    rd_chk("R2", 8'h31, 8'h00);
    for (int a = 8'h32; a <= 8'h38; a++) wr(8'(a), 8'h00);
  endtask

  task automatic t_bypass();
    logic prev;
    logic [4:0] pat;
    pat = 5'b01101;
    prev = de_out;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      de_ext_in = pat[i];
      #1;
      chk("R8", int'(de_out), int'(prev), "bypass before edge");
      @(negedge clk);
      chk("R8", int'(de_out), int'(pat[i]), "bypass one clock later");
      prev = pat[i];
    end
    de_ext_in = 1'b0;
  endtask

  task automatic cfg_frame(input int d, input int w, input int t, input int h, input bit hp, input bit vp);
    hact = hp; vact = vp;
    hsync_in = ~hp; vsync_in = ~vp;
    wr(8'h32, 8'(d & 8'hFF));
    wr(8'h35, 8'(w & 8'hFF)); wr(8'h36, 8'((w >> 8) & 8'h0F));
    wr(8'h34, 8'(t));
    wr(8'h37, 8'(h & 8'hFF)); wr(8'h38, 8'((h >> 8) & 8'h07));
    wr(8'h33, 8'h40 | 8'(vp) << 5 | 8'(hp) << 4 | 8'((d >> 8) & 1));
    repeat (2) @(negedge clk);
  endtask

  task automatic frame_check(input string req);
    int f, c;
    de_ext_in = 1'b1;
    run_line(1'b1, 16, f, c);
    chk("R7", c, 0, {req, " line0 above top, ext enable high"});
    run_line(1'b0, 16, f, c);
    chk(req, c, 4, "line1 width");
    chk("R9", f, 5, "line1 first enable sample");
    run_line(1'b0, 16, f, c);
    chk("R5", c, 4, "line2 last active line");
    run_line(1'b0, 16, f, c);
    chk("R5", c, 0, "line3 below window");
    de_ext_in = 1'b0;
  endtask

  task automatic t_frame();
    cfg_frame(3, 4, 1, 2, 1'b1, 1'b1);
    frame_check("R4");
  endtask

  task automatic t_polarity();
    cfg_frame(3, 4, 1, 2, 1'b0, 1'b0);
    frame_check("R3");
  endtask

  task automatic t_long_delay();
    int f, c;
    cfg_frame(258, 3, 0, 1, 1'b1, 1'b1);
    rd_chk("R2", 8'h33, 8'h71);
    run_line(1'b1, 270, f, c);
    chk("R4", f, 260, "9-bit delay first sample");
    chk("R4", c, 3, "9-bit delay width");
  endtask

  task automatic t_saturate();
    int f, c;
    cfg_frame(0, 2, 0, 2047, 1'b1, 1'b1);
    run_line(1'b1, 4, f, c);
    chk("R5", c, 2, "line0 after vsync");
    for (int i = 0; i < 4100; i++) run_line(1'b0, 4, f, c);
    run_line(1'b0, 4, f, c);
    chk("R6", c, 0, "saturated line count outside window");
    run_line(1'b1, 4, f, c);
    chk("R6", c, 2, "vsync restarts saturated count");
    cfg_frame(0, 0, 0, 2047, 1'b1, 1'b1);
    run_line(1'b1, 4, f, c);
    chk("R4", c, 0, "zero width gives no enable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bypass();
    t_frame();
    t_polarity();
    t_long_delay();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule